// File: doc/BRIEF.md
# Motion Burst Report Reader

This block fetches one motion report from an optical motion sensor over a four-wire serial link (SPI mode 3) each time the host pulses `poll`. The sensor has a burst mode that must be switched on by a single register write before burst reads give valid data. The reader remembers whether that write has been made. A poll while burst mode is off first sends the arming write in its own chip-select frame, and then performs the burst read. A report whose low status bits flag a fault turns the armed state off, so the next poll arms the sensor again.

A burst read is one chip-select frame. It sends the burst register address with the write bit clear and waits a programmable read-address delay. It then clocks six bytes: status, a discarded observation byte, and the low and high bytes of X and then of Y. The reader turns these into a signed 16-bit X delta with its sign inverted, a signed 16-bit Y delta, a motion flag and a surface-contact flag. All four outputs update together with a one-cycle `valid` pulse. The host may also write any sensor register through `wr_req`. A write to any register other than the burst register turns the armed state off.

Top module: `mburst_reader`

## Requirements
- R1: After synchronous reset `cs_n`=1, `sclk`=1, `valid`=0 and `busy`=0, and burst mode counts as not armed.
- R2: The link runs in SPI mode 3, most significant bit first. `sclk` idles high, `mosi` changes only while `sclk` is low, and `miso` is sampled on the rising edge of `sclk`. The low and high phases each last `HALF_CYC` clocks.
- R3: A poll while not armed first sends a two-byte frame {1,BURST_ADDR[6:0]} then 8'h00, releases `cs_n`, and marks burst mode as armed. It then goes straight on to the burst read. A poll while armed sends no arming frame.
- R4: A burst read is one frame of seven bytes. Its first byte is {0,BURST_ADDR[6:0]}, and at least `RAD_CYC` clocks pass between the last rising `sclk` edge of that byte and the first falling edge of the next. `cs_n` rises only after the seventh byte.
- R5: The six bytes after the address are taken as status, observation, X low, X high, Y low, Y high. The observation byte has no effect on any output.
- R6: `is_motion` equals status bit 7. `on_surface` is 1 exactly when status bit 3 is 0.
- R7: `dx` is the 16-bit two's-complement negation of {X high, X low}, so 16'h8000 maps to itself. `dy` is {Y high, Y low} unchanged.
- R8: If any of status bits 2..0 are 1, the armed state is cleared, and the next poll sends the arming frame again.
- R9: A host write sends a two-byte frame {1,`wr_addr`} then `wr_data`, and produces no `valid`. If `wr_addr` differs from BURST_ADDR the armed state is cleared; if it is equal the armed state is left as it was.
- R10: `valid` is high for exactly one clock per completed read. `dx`, `dy`, `is_motion` and `on_surface` change only in that cycle and hold their values otherwise.
- R11: `busy` is high from the accepted strobe until the operation ends. `poll` and `wr_req` are ignored while `busy` is high. If both are high in the same idle cycle, the write is done and the poll is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| poll | input | 1 | Request one motion report |
| wr_req | input | 1 | Request a sensor register write |
| wr_addr | input | 7 | Register address for the write |
| wr_data | input | 8 | Data byte for the write |
| busy | output | 1 | An operation is in progress |
| valid | output | 1 | One-cycle pulse: report outputs updated |
| dx | output | 16 | Signed X delta, sign inverted |
| dy | output | 16 | Signed Y delta |
| is_motion | output | 1 | Motion flag from the report |
| on_surface | output | 1 | Surface-contact flag from the report |
| cs_n | output | 1 | Sensor chip select, active low |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data to the sensor |
| miso | input | 1 | Serial data from the sensor |

## Verification
The assertions assume that `miso` is already stable and synchronous to `clk` when the reader samples it on a rising `sclk`. The sensor model in the bench meets this by changing `miso` only on falling `sclk` edges, at least `HALF_CYC` clocks before the next sample. They also assume that the host raises strobes only when it expects them to be accepted or to be ignored by rule. The bench raises `poll` or `wr_req` for a single clock, away from the clock edge, and raises a strobe during `busy` only in the test that checks it is ignored.

// File: rtl/mburst_pkg.sv
package mburst_pkg;

  // data bytes clocked after the address byte of a burst read
  localparam int FRAME_DATA_BYTES = 6;
  // bytes kept for the report: status, X low, X high, Y low, Y high
  localparam int REP_BYTES = 5;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LEAD,
    S_XFER,
    S_RAD,
    S_TAIL,
    S_GAP
  } seq_state_t;

  typedef enum logic [1:0] {
    OP_ARM,
    OP_READ,
    OP_WRITE
  } seq_op_t;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/mburst_spi_byte.sv
module mburst_spi_byte #(
  parameter int HALF_CYC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx,
  output logic       done,
  output logic [7:0] rx,
  output logic       active,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);

  localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [HW-1:0] HALF_LOAD = HW'(HALF_CYC - 1);

  logic [HW-1:0] cnt;
  logic [2:0]    bitn;
  logic          hi;
  logic [7:0]    sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      bitn   <= 3'd0;
      hi     <= 1'b0;
      sh     <= 8'h00;
      rx     <= 8'h00;
      done   <= 1'b0;
      active <= 1'b0;
      sclk   <= 1'b1;
      mosi   <= 1'b1;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          sh     <= tx;
          bitn   <= 3'd7;
          hi     <= 1'b0;
          sclk   <= 1'b0;
          mosi   <= tx[7];
          cnt    <= HALF_LOAD;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else if (!hi) begin
        // rising edge: sample the sensor bit
        sclk <= 1'b1;
        rx   <= {rx[6:0], miso};
        hi   <= 1'b1;
        cnt  <= HALF_LOAD;
      end else if (bitn == 3'd0) begin
        active <= 1'b0;
        done   <= 1'b1;
      end else begin
        // falling edge: present the next bit
        bitn <= bitn - 1'b1;
        sclk <= 1'b0;
        mosi <= sh[bitn - 1'b1];
        hi   <= 1'b0;
        cnt  <= HALF_LOAD;
      end
    end
  end

  p_sclk_idle_high_r2 : assert property (@(posedge clk) disable iff (rst)
    !active |-> sclk);

  p_mosi_moves_low_r2 : assert property (@(posedge clk) disable iff (rst)
    !$stable(mosi) |-> !sclk);

  p_done_pulse_r2 : assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/mburst_seq.sv
module mburst_seq
  import mburst_pkg::*;
#(
  parameter logic [6:0] BURST_ADDR  = 7'h50,
  parameter int         LEAD_CYC    = 50,
  parameter int         RAD_CYC     = 1750,
  parameter int         WR_TAIL_CYC = 6000,
  parameter int         RD_TAIL_CYC = 1000,
  parameter int         GAP_CYC     = 50
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        poll,
  input  logic                        wr_req,
  input  logic [6:0]                  wr_addr,
  input  logic [7:0]                  wr_data,
  output logic                        busy,
  output logic                        cs_n,
  output logic                        eng_start,
  output logic [7:0]                  eng_tx,
  input  logic                        eng_done,
  input  logic [7:0]                  eng_rx,
  output logic                        cap_done,
  output logic [REP_BYTES-1:0][7:0]   rep
);

  localparam int MAX_CYC = max_int(max_int(max_int(LEAD_CYC, RAD_CYC),
                                           max_int(WR_TAIL_CYC, RD_TAIL_CYC)),
                                   GAP_CYC);
  localparam int TW = $clog2(MAX_CYC + 1);
  localparam logic [TW-1:0] LEAD_LD  = TW'(LEAD_CYC - 1);
  localparam logic [TW-1:0] RAD_LD   = TW'(RAD_CYC - 1);
  localparam logic [TW-1:0] WRT_LD   = TW'(WR_TAIL_CYC - 1);
  localparam logic [TW-1:0] RDT_LD   = TW'(RD_TAIL_CYC - 1);
  localparam logic [TW-1:0] GAP_LD   = TW'(GAP_CYC - 1);
  localparam logic [2:0]    LAST_IDX = 3'(FRAME_DATA_BYTES);
  localparam logic [2:0]    OBS_IDX  = 3'd2;

  seq_state_t state;
  seq_op_t    op;
  logic [TW-1:0] tmr;
  logic [2:0]    bidx;
  logic          armed;
  logic [6:0]    wa;
  logic [7:0]    wd;

  logic fin;
  assign fin  = (state == S_GAP) && (tmr == '0);
  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      op        <= OP_READ;
      tmr       <= '0;
      bidx      <= 3'd0;
      armed     <= 1'b0;
      wa        <= 7'h00;
      wd        <= 8'h00;
      cs_n      <= 1'b1;
      eng_start <= 1'b0;
      eng_tx    <= 8'h00;
      cap_done  <= 1'b0;
      rep       <= '0;
    end else begin
      eng_start <= 1'b0;
      cap_done  <= 1'b0;
      case (state)
        S_IDLE: begin
          if (wr_req || poll) begin
            if (wr_req) begin
              op <= OP_WRITE;
              wa <= wr_addr;
              wd <= wr_data;
            end else begin
              op <= armed ? OP_READ : OP_ARM;
            end
            cs_n  <= 1'b0;
            tmr   <= LEAD_LD;
            bidx  <= 3'd0;
            state <= S_LEAD;
          end
        end
        S_LEAD: begin
          if (tmr != '0) begin
            tmr <= tmr - 1'b1;
          end else begin
            eng_start <= 1'b1;
            if (op == OP_READ)     eng_tx <= {1'b0, BURST_ADDR};
            else if (op == OP_ARM) eng_tx <= {1'b1, BURST_ADDR};
            else                   eng_tx <= {1'b1, wa};
            state <= S_XFER;
          end
        end
        S_XFER: begin
          if (eng_done) begin
            if (op == OP_READ) begin
              if (bidx == 3'd1) rep[0] <= eng_rx;
              else if (bidx > OBS_IDX) rep[bidx - 3'd2] <= eng_rx;
              if (bidx == 3'd0) begin
                bidx  <= 3'd1;
                tmr   <= RAD_LD;
                state <= S_RAD;
              end else if (bidx == LAST_IDX) begin
                tmr   <= RDT_LD;
                state <= S_TAIL;
              end else begin
                bidx      <= bidx + 3'd1;
                eng_start <= 1'b1;
                eng_tx    <= 8'h00;
              end
            end else begin
              if (bidx == 3'd0) begin
                bidx      <= 3'd1;
                eng_start <= 1'b1;
                eng_tx    <= (op == OP_ARM) ? 8'h00 : wd;
              end else begin
                tmr   <= WRT_LD;
                state <= S_TAIL;
              end
            end
          end
        end
        S_RAD: begin
          if (tmr != '0) begin
            tmr <= tmr - 1'b1;
          end else begin
            eng_start <= 1'b1;
            eng_tx    <= 8'h00;
            state     <= S_XFER;
          end
        end
        S_TAIL: begin
          if (tmr != '0) begin
            tmr <= tmr - 1'b1;
          end else begin
            cs_n  <= 1'b1;
            tmr   <= GAP_LD;
            state <= S_GAP;
          end
        end
        S_GAP: begin
          if (tmr != '0) begin
            tmr <= tmr - 1'b1;
          end else begin
            case (op)
              OP_ARM: begin
                armed <= 1'b1;
                op    <= OP_READ;
                cs_n  <= 1'b0;
                tmr   <= LEAD_LD;
                bidx  <= 3'd0;
                state <= S_LEAD;
              end
              OP_READ: begin
                cap_done <= 1'b1;
                if (rep[0][2:0] != 3'b000) armed <= 1'b0;
                state <= S_IDLE;
              end
              default: begin
                if (wa != BURST_ADDR) armed <= 1'b0;
                state <= S_IDLE;
              end
            endcase
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_idle_cs_high_r4 : assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> cs_n);

  p_arm_then_read_r3 : assert property (@(posedge clk) disable iff (rst)
    (fin && op == OP_ARM) |=> (armed && op == OP_READ && !cs_n));

  p_read_needs_arm_r3 : assert property (@(posedge clk) disable iff (rst)
    (state == S_XFER && op == OP_READ) |-> armed);

  p_fault_disarms_r8 : assert property (@(posedge clk) disable iff (rst)
    (fin && op == OP_READ && rep[0][2:0] != 3'b000) |=> !armed);

  p_other_write_disarms_r9 : assert property (@(posedge clk) disable iff (rst)
    (fin && op == OP_WRITE && wa != BURST_ADDR) |=> !armed);

  p_burst_write_keeps_r9 : assert property (@(posedge clk) disable iff (rst)
    (fin && op == OP_WRITE && wa == BURST_ADDR) |=> $stable(armed));

  p_cap_only_after_read_r10 : assert property (@(posedge clk) disable iff (rst)
    cap_done |-> ($past(op) == OP_READ && state == S_IDLE));

endmodule

// File: rtl/mburst_assemble.sv
module mburst_assemble
  import mburst_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cap_done,
  input  logic [REP_BYTES-1:0][7:0] rep,
  output logic                      valid,
  output logic [15:0]               dx,
  output logic [15:0]               dy,
  output logic                      is_motion,
  output logic                      on_surface
);

  logic [15:0] x_raw;
  logic [15:0] y_raw;
  assign x_raw = {rep[2], rep[1]};
  assign y_raw = {rep[4], rep[3]};

  always_ff @(posedge clk) begin
    if (rst) begin
      valid      <= 1'b0;
      dx         <= 16'h0000;
      dy         <= 16'h0000;
      is_motion  <= 1'b0;
      on_surface <= 1'b0;
    end else begin
      valid <= cap_done;
      if (cap_done) begin
        dx         <= 16'h0000 - x_raw;
        dy         <= y_raw;
        is_motion  <= rep[0][7];
        on_surface <= ~rep[0][3];
      end
    end
  end

  p_valid_pulse_r10 : assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  p_hold_dx_r10 : assert property (@(posedge clk) disable iff (rst)
    !valid |-> ($stable(dx) && $stable(dy)));

  p_hold_flags_r10 : assert property (@(posedge clk) disable iff (rst)
    !valid |-> ($stable(is_motion) && $stable(on_surface)));

endmodule

// File: rtl/mburst_reader.sv
module mburst_reader
  import mburst_pkg::*;
#(
  parameter logic [6:0] BURST_ADDR  = 7'h50,
  parameter int         HALF_CYC    = 2,
  parameter int         LEAD_CYC    = 50,
  parameter int         RAD_CYC     = 1750,
  parameter int         WR_TAIL_CYC = 6000,
  parameter int         RD_TAIL_CYC = 1000,
  parameter int         GAP_CYC     = 50
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        poll,
  input  logic        wr_req,
  input  logic [6:0]  wr_addr,
  input  logic [7:0]  wr_data,
  output logic        busy,
  output logic        valid,
  output logic [15:0] dx,
  output logic [15:0] dy,
  output logic        is_motion,
  output logic        on_surface,
  output logic        cs_n,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso
);

  logic                      eng_start;
  logic [7:0]                eng_tx;
  logic                      eng_done;
  logic [7:0]                eng_rx;
  logic                      eng_busy;
  logic                      cap_done;
  logic [REP_BYTES-1:0][7:0] rep;

  mburst_seq #(
    .BURST_ADDR (BURST_ADDR),
    .LEAD_CYC   (LEAD_CYC),
    .RAD_CYC    (RAD_CYC),
    .WR_TAIL_CYC(WR_TAIL_CYC),
    .RD_TAIL_CYC(RD_TAIL_CYC),
    .GAP_CYC    (GAP_CYC)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .poll     (poll),
    .wr_req   (wr_req),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .busy     (busy),
    .cs_n     (cs_n),
    .eng_start(eng_start),
    .eng_tx   (eng_tx),
    .eng_done (eng_done),
    .eng_rx   (eng_rx),
    .cap_done (cap_done),
    .rep      (rep)
  );

  mburst_spi_byte #(
    .HALF_CYC(HALF_CYC)
  ) u_spi (
    .clk   (clk),
    .rst   (rst),
    .start (eng_start),
    .tx    (eng_tx),
    .done  (eng_done),
    .rx    (eng_rx),
    .active(eng_busy),
    .sclk  (sclk),
    .mosi  (mosi),
    .miso  (miso)
  );

  mburst_assemble u_asm (
    .clk       (clk),
    .rst       (rst),
    .cap_done  (cap_done),
    .rep       (rep),
    .valid     (valid),
    .dx        (dx),
    .dy        (dy),
    .is_motion (is_motion),
    .on_surface(on_surface)
  );

  p_start_when_free_r2 : assert property (@(posedge clk) disable iff (rst)
    eng_start |-> !eng_busy);

  p_clock_inside_frame_r4 : assert property (@(posedge clk) disable iff (rst)
    eng_busy |-> !cs_n);

  p_cap_gives_valid_r10 : assert property (@(posedge clk) disable iff (rst)
    cap_done |=> valid);

endmodule

// File: tb/mburst_reader_tb.sv
`timescale 1ns/1ps
module mburst_reader_tb;

  localparam logic [6:0] BA = 7'h50;
  localparam int HALF = 2;
  localparam int LEAD = 4;
  localparam int RAD  = 40;
  localparam int WRT  = 20;
  localparam int RDT  = 10;
  localparam int GAP  = 4;
  localparam int WDOG = 150000;

  typedef struct packed {
    logic [7:0]  st;
    logic [7:0]  obs;
    logic [7:0]  xl;
    logic [7:0]  xh;
    logic [7:0]  yl;
    logic [7:0]  yh;
    logic [15:0] edx;
    logic [15:0] edy;
    logic        emot;
    logic        esurf;
    logic        earm;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{8'h80, 8'hA5, 8'h05, 8'h00, 8'h03, 8'h00, 16'hFFFB, 16'h0003, 1'b1, 1'b1, 1'b1},
    '{8'h88, 8'hFF, 8'hFE, 8'hFF, 8'h00, 8'h80, 16'h0002, 16'h8000, 1'b1, 1'b0, 1'b0},
    '{8'h00, 8'h00, 8'h00, 8'h80, 8'hFF, 8'h7F, 16'h8000, 16'h7FFF, 1'b0, 1'b1, 1'b0},
    '{8'h81, 8'h5A, 8'h34, 8'h12, 8'hCD, 8'hAB, 16'hEDCC, 16'hABCD, 1'b1, 1'b1, 1'b0},
    '{8'h80, 8'hC3, 8'h00, 8'h00, 8'h01, 8'h00, 16'h0000, 16'h0001, 1'b1, 1'b1, 1'b1},
    '{8'h06, 8'h12, 8'h01, 8'h00, 8'h00, 8'h00, 16'hFFFF, 16'h0000, 1'b0, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic poll = 1'b0;
  logic wr_req = 1'b0;
  logic [6:0] wr_addr = 7'h00;
  logic [7:0] wr_data = 8'h00;
  logic busy, valid, is_motion, on_surface, cs_n, sclk, mosi;
  logic miso;
  logic [15:0] dx, dy;

  always #10 clk = ~clk;

  mburst_reader #(
    .BURST_ADDR (BA),
    .HALF_CYC   (HALF),
    .LEAD_CYC   (LEAD),
    .RAD_CYC    (RAD),
    .WR_TAIL_CYC(WRT),
    .RD_TAIL_CYC(RDT),
    .GAP_CYC    (GAP)
  ) u_dut (
    .clk(clk), .rst(rst), .poll(poll), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .valid(valid), .dx(dx), .dy(dy),
    .is_motion(is_motion), .on_surface(on_surface), .cs_n(cs_n),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  int nchk = 0;
  int nbad = 0;
  bit done_flag = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- sensor model ----------------
  logic [7:0] resp [6];
  logic [7:0] mshift = 8'h00;
  int nbits = 0;
  int fr_n = 0;
  int fr_len [64];
  logic [7:0] fr_b0 [64];
  logic [7:0] fr_b1 [64];
  realtime t8 = 0.0;
  realtime t9 = 0.0;
  int fidx = 0;
  logic miso_r = 1'b1;
  assign miso = miso_r;

  always @(posedge sclk or posedge cs_n) begin
    if (cs_n === 1'b1) begin
      if (nbits > 0) begin
        fr_len[fr_n % 64] = nbits / 8;
        fr_n = fr_n + 1;
        nbits = 0;
      end
    end else begin
      mshift = {mshift[6:0], mosi};
      nbits = nbits + 1;
      if (nbits == 8) begin
        fr_b0[fr_n % 64] = mshift;
        t8 = $realtime;
      end
      if (nbits == 16) fr_b1[fr_n % 64] = mshift;
    end
  end

  always @(negedge sclk or negedge cs_n) begin
    if (sclk === 1'b1) begin
      fidx = 0;
    end else if (cs_n === 1'b0) begin
      if (fidx == 8) t9 = $realtime;
      if (fidx / 8 >= 1 && fidx / 8 <= 6)
        miso_r = resp[fidx / 8 - 1][7 - (fidx % 8)];
      else
        miso_r = 1'b1;
      fidx = fidx + 1;
    end
  end

  int vcnt = 0;
  always @(posedge clk) if (valid === 1'b1) vcnt = vcnt + 1;

  int cyc = 0;
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > WDOG && !done_flag) begin
      done_flag = 1'b1;
      nchk++;
      nbad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  // ---------------- tasks ----------------
  task automatic load_resp(input vec_t v);
    resp[0] = v.st;  resp[1] = v.obs; resp[2] = v.xl;
    resp[3] = v.xh;  resp[4] = v.yl;  resp[5] = v.yh;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  // poll, wait for valid, check frames and outputs
  task automatic run_poll(input vec_t v, input string name);
    int f0;
    int nf;
    int last;
    logic [15:0] hdx;
    load_resp(v);
    wait_idle();
    f0 = fr_n;
    poll = 1'b1;
    @(negedge clk);
    poll = 1'b0;
    while (!valid) @(negedge clk);
    nf = fr_n - f0;
    last = (fr_n - 1) % 64;
    chk(nf == (v.earm ? 2 : 1), {name, " R3/R8 frame count"}, nf, v.earm ? 2 : 1);
    if (v.earm) begin
      chk(fr_len[f0 % 64] == 2, {name, " R3 arm frame length"}, fr_len[f0 % 64], 2);
      chk(fr_b0[f0 % 64] == {1'b1, BA}, {name, " R2 R3 arm address byte"},
          fr_b0[f0 % 64], {1'b1, BA});
      chk(fr_b1[f0 % 64] == 8'h00, {name, " R3 arm data byte"}, fr_b1[f0 % 64], 0);
    end
    chk(fr_len[last] == 7, {name, " R4 read frame length"}, fr_len[last], 7);
    chk(fr_b0[last] == {1'b0, BA}, {name, " R4 read address byte"}, fr_b0[last], {1'b0, BA});
    chk((t9 - t8) >= RAD * 20.0, {name, " R4 read-address wait"},
        int'((t9 - t8) / 20.0), RAD);
    chk(dx == v.edx, {name, " R7 dx"}, dx, v.edx);
    chk(dy == v.edy, {name, " R5 R7 dy"}, dy, v.edy);
    chk(is_motion == v.emot, {name, " R6 is_motion"}, is_motion, v.emot);
    chk(on_surface == v.esurf, {name, " R6 on_surface"}, on_surface, v.esurf);
    hdx = dx;
    @(negedge clk);
    chk(valid == 1'b0, {name, " R10 valid one cycle"}, valid, 0);
    chk(dx == hdx, {name, " R10 dx holds"}, dx, hdx);
  endtask

  task automatic run_write(input logic [6:0] a, input logic [7:0] d, input bit with_poll,
                           input string name);
    int f0;
    int v0;
    wait_idle();
    f0 = fr_n;
    v0 = vcnt;
    wr_addr = a;
    wr_data = d;
    wr_req = 1'b1;
    poll = with_poll;
    @(negedge clk);
    wr_req = 1'b0;
    poll = 1'b0;
    wait_idle();
    repeat (20) @(negedge clk);
    chk(fr_n - f0 == 1, {name, " R9 R11 one frame"}, fr_n - f0, 1);
    chk(fr_len[f0 % 64] == 2, {name, " R9 frame length"}, fr_len[f0 % 64], 2);
    chk(fr_b0[f0 % 64] == {1'b1, a}, {name, " R9 address byte"}, fr_b0[f0 % 64], {1'b1, a});
    chk(fr_b1[f0 % 64] == d, {name, " R9 data byte"}, fr_b1[f0 % 64], d);
    chk(vcnt == v0, {name, " R9 R11 no valid"}, vcnt, v0);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    vec_t w;
    int f0;
    int v0;
    for (int i = 0; i < 6; i++) resp[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 1'b1, "R1 cs_n after reset", cs_n, 1);
    chk(sclk == 1'b1, "R1 R2 sclk idles high", sclk, 1);
    chk(valid == 1'b0, "R1 valid after reset", valid, 0);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(dx == 16'h0 && dy == 16'h0, "R1 deltas after reset", {dx, dy}, 0);

    // table walk: first entry also checks arming after reset (R1, R3)
    for (int i = 0; i < 6; i++) run_poll(VEC[i], $sformatf("vec%0d", i));

    // after fault status in the last entry the next poll re-arms (R8)
    w = '{8'h08, 8'h77, 8'h00, 8'hFF, 8'h00, 8'h01, 16'h0100, 16'h0100, 1'b0, 1'b0, 1'b1};
    run_poll(w, "rearm R8");

    // same report data, different observation byte: no effect (R5)
    w.obs = 8'h11; w.earm = 1'b0;
    run_poll(w, "obs R5");

    // write to another register and a simultaneous poll: write wins, disarms (R9, R11)
    run_write(7'h10, 8'h3C, 1'b1, "wr_other");
    w.earm = 1'b1;
    run_poll(w, "after_wr_other R9");

    // write to the burst register leaves the armed state (R9)
    run_write(BA, 8'h00, 1'b0, "wr_burst");
    w.earm = 1'b0;
    run_poll(w, "after_wr_burst R9");

    // poll raised while busy is ignored (R11)
    load_resp(VEC[0]);
    wait_idle();
    f0 = fr_n;
    v0 = vcnt;
    poll = 1'b1;
    @(negedge clk);
    poll = 1'b0;
    repeat (30) @(negedge clk);
    chk(busy == 1'b1, "R11 busy during read", busy, 1);
    poll = 1'b1;
    wr_req = 1'b1;
    wr_addr = 7'h22;
    @(negedge clk);
    poll = 1'b0;
    wr_req = 1'b0;
    wait_idle();
    repeat (400) @(negedge clk);
    chk(vcnt - v0 == 1, "R11 strobe during busy ignored (valid)", vcnt - v0, 1);
    chk(fr_n - f0 == 1, "R11 strobe during busy ignored (frames)", fr_n - f0, 1);
    chk(dx == VEC[0].edx, "R11 R7 dx of accepted poll", dx, VEC[0].edx);

    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

endmodule